// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a hung two-wire bus back to a clean idle state before the main I2C controller is put to work. A single-cycle start request launches a fixed sequence. First it clears the controller's sticky status bits. It then gives any transfer still in flight a bounded time to finish. Next it holds the controller in soft reset and toggles the clock line until no device is holding either line low. It then forces a START followed by a STOP onto the bus. Last it releases the controller and waits a settling time before it reports completion.

Both bus lines are handled as open-drain: the block only ever asks for a line to be pulled low and otherwise leaves it released. The sensed line levels pass through a two-flop synchroniser before the sequencer uses them. All waits are whole microseconds, counted from one tick made by a prescaler of the system clock, so the sequence timing scales with a single parameter. Arbitration with other masters and any data transfer are not part of the block.

Top module: `i2cBusRecover`

## Requirements
- R1: After reset, `busy`, `ctrlSoftReset`, `sclDriveLow`, `sdaDriveLow`, `clearSticky` and `donePulse` are all 0. A `startPulse` while idle raises `busy` and makes `clearSticky` high for exactly one cycle.
- R2: The pending flag is sampled at most POLL_LIMIT times, with POLL_WAIT_US microseconds between samples, and the sequence goes on even if the flag is still set. The first cycle of `ctrlSoftReset` high comes 2 cycles after the `clearSticky` cycle when nothing is pending. When the flag stays set it comes 2 + (POLL_LIMIT-1)*(POLL_WAIT_US*CLK_PER_US+2) cycles after that cycle.
- R3: `ctrlSoftReset` is high in every cycle in which either line is pulled. It is released HOLD_US*CLK_PER_US+1 cycles after SDA is let go for the STOP.
- R4: While either synchronised line reads low, SCL is pulled for HALF_US*CLK_PER_US+1 cycles per pulse and released for HALF_US*CLK_PER_US+2 cycles between pulses, with SDA released. Pulsing stops once both lines read high.
- R5: No more than PULSE_LIMIT clock pulses are issued in one sequence, even if a line stays low.
- R6: After pulsing, SDA is pulled while SCL is released (START). SDA stays pulled for HOLD_US*CLK_PER_US+1 cycles and is then released (STOP).
- R7: `donePulse` is high for one cycle, SETTLE_US*CLK_PER_US+1 cycles after the first cycle with `ctrlSoftReset` low. `busy` is 0 in the following cycle.
- R8: A `startPulse` while `busy` is high has no effect: no second status clear, no change to the running sequence, and the block is idle after the sequence finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to run the recovery sequence |
| pendingIn | input | 1 | Controller reports a transfer still in progress |
| sclIn | input | 1 | Sensed SCL line level (asynchronous) |
| sdaIn | input | 1 | Sensed SDA line level (asynchronous) |
| busy | output | 1 | Sequence in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| clearSticky | output | 1 | One-cycle strobe clearing the controller's sticky status bits |
| ctrlSoftReset | output | 1 | Holds the main controller in soft reset |
| sclDriveLow | output | 1 | Open-drain enable pulling SCL low |
| sdaDriveLow | output | 1 | Open-drain enable pulling SDA low |

## Verification
The bound checker watches, on every cycle, that soft reset covers all line driving, that the two lines are never pulled together, that the START pulls SDA only with SCL released, that the clock pulse count stays within its limit, and that both the status clear and the completion strobe last one cycle and leave the block in a quiet state. The exact cycle counts can only be shown by the bench's scenarios: the poll-wait spacing, the pulse widths and gaps, the hold and settle times, and the pulse count for a device that lets go after a given number of clocks. The same holds for the sequence running to the limit with a stuck line, and for a second start request being ignored.

// File: rtl/i2cRecoverPkg.sv
package i2cRecoverPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_POLL,
    ST_POLL_WAIT,
    ST_SRST,
    ST_CHECK,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_START_HOLD,
    ST_STOP_HOLD,
    ST_SETTLE,
    ST_DONE
  } recState_e;

  typedef enum logic [1:0] {
    DLY_POLL,
    DLY_HALF,
    DLY_HOLD,
    DLY_SETTLE
  } dlySel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    timerLoad;
    dlySel_e dlySel;
    logic    pollInc;
    logic    pulseInc;
    logic    cntClear;
    logic    sclPull;
    logic    sclRelease;
    logic    sdaPull;
    logic    sdaRelease;
    logic    rstAssert;
    logic    rstRelease;
  } recStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic timerDone;
    logic pollLast;
    logic pulseLast;
    logic linesHigh;
  } recStatus_t;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) begin
          chain[s] <= {WIDTH{RESET_VAL}};
        end else begin
          if (s == 0) chain[s] <= asyncIn;
          else        chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/i2cUsTimer.sv
module i2cUsTimer #(
  parameter int CLK_PER_US = 100,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             done
);

  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] usLeft;
  logic             usTick;

  assign usTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      usLeft <= '0;
    end else if (load) begin
      preCnt <= '0;
      usLeft <= loadVal;
    end else if (usLeft != '0) begin
      if (usTick) begin
        preCnt <= '0;
        usLeft <= usLeft - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign done = (usLeft == '0);

endmodule

// File: rtl/i2cRecoverDatapath.sv
module i2cRecoverDatapath
  import i2cRecoverPkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int POLL_LIMIT = 10,
  parameter int POLL_WAIT_US = 500,
  parameter int PULSE_LIMIT = 10,
  parameter int HALF_US = 100,
  parameter int HOLD_US = 1000,
  parameter int SETTLE_US = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  recStrobe_t stb,
  input  logic       sclIn,
  input  logic       sdaIn,
  output recStatus_t stat,
  output logic       ctrlSoftReset,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);

  function automatic int maxOf2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_DLY = maxOf2(maxOf2(POLL_WAIT_US, HALF_US), maxOf2(HOLD_US, SETTLE_US));
  localparam int CNT_W = $clog2(MAX_DLY + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int PULSE_W = $clog2(PULSE_LIMIT + 1);

  logic [1:0]         lineSync;
  logic [CNT_W-1:0]   dlyVal;
  logic [POLL_W-1:0]  pollCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               timerDone;

  i2cLineSync #(
    .WIDTH(2),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) sync_i (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({sclIn, sdaIn}),
    .syncOut(lineSync)
  );

  always_comb begin
    unique case (stb.dlySel)
      DLY_POLL: dlyVal = CNT_W'(POLL_WAIT_US);
      DLY_HALF: dlyVal = CNT_W'(HALF_US);
      DLY_HOLD: dlyVal = CNT_W'(HOLD_US);
      default:  dlyVal = CNT_W'(SETTLE_US);
    endcase
  end

  i2cUsTimer #(
    .CLK_PER_US(CLK_PER_US),
    .CNT_W(CNT_W)
  ) timer_i (
    .clk(clk),
    .rstN(rstN),
    .load(stb.timerLoad),
    .loadVal(dlyVal),
    .done(timerDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt  <= '0;
      pulseCnt <= '0;
    end else if (stb.cntClear) begin
      pollCnt  <= '0;
      pulseCnt <= '0;
    end else begin
      if (stb.pollInc)  pollCnt  <= pollCnt + 1'b1;
      if (stb.pulseInc) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlSoftReset <= 1'b0;
      sclDriveLow   <= 1'b0;
      sdaDriveLow   <= 1'b0;
    end else begin
      if (stb.rstAssert)       ctrlSoftReset <= 1'b1;
      else if (stb.rstRelease) ctrlSoftReset <= 1'b0;
      if (stb.sclPull)         sclDriveLow <= 1'b1;
      else if (stb.sclRelease) sclDriveLow <= 1'b0;
      if (stb.sdaPull)         sdaDriveLow <= 1'b1;
      else if (stb.sdaRelease) sdaDriveLow <= 1'b0;
    end
  end

  assign stat.timerDone = timerDone;
  assign stat.pollLast  = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign stat.pulseLast = (pulseCnt == PULSE_W'(PULSE_LIMIT));
  assign stat.linesHigh = lineSync[1] & lineSync[0];

endmodule

// File: rtl/i2cRecoverControl.sv
module i2cRecoverControl
  import i2cRecoverPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       pendingIn,
  input  recStatus_t stat,
  output recStrobe_t stb,
  output logic       busy,
  output logic       clearSticky,
  output logic       donePulse
);

  recState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) nextState = ST_CLEAR;
      end
      ST_CLEAR: begin
        stb.cntClear = 1'b1;
        nextState = ST_POLL;
      end
      ST_POLL: begin
        if (!pendingIn || stat.pollLast) begin
          stb.rstAssert = 1'b1;
          nextState = ST_SRST;
        end else begin
          stb.pollInc = 1'b1;
          stb.timerLoad = 1'b1;
          stb.dlySel = DLY_POLL;
          nextState = ST_POLL_WAIT;
        end
      end
      ST_POLL_WAIT: begin
        if (stat.timerDone) nextState = ST_POLL;
      end
      ST_SRST: begin
        stb.sclRelease = 1'b1;
        stb.sdaRelease = 1'b1;
        stb.cntClear = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (stat.linesHigh || stat.pulseLast) begin
          stb.sdaPull = 1'b1;
          stb.timerLoad = 1'b1;
          stb.dlySel = DLY_HOLD;
          nextState = ST_START_HOLD;
        end else begin
          stb.sclPull = 1'b1;
          stb.pulseInc = 1'b1;
          stb.timerLoad = 1'b1;
          stb.dlySel = DLY_HALF;
          nextState = ST_PULSE_LO;
        end
      end
      ST_PULSE_LO: begin
        if (stat.timerDone) begin
          stb.sclRelease = 1'b1;
          stb.timerLoad = 1'b1;
          stb.dlySel = DLY_HALF;
          nextState = ST_PULSE_HI;
        end
      end
      ST_PULSE_HI: begin
        if (stat.timerDone) nextState = ST_CHECK;
      end
      ST_START_HOLD: begin
        if (stat.timerDone) begin
          stb.sdaRelease = 1'b1;
          stb.timerLoad = 1'b1;
          stb.dlySel = DLY_HOLD;
          nextState = ST_STOP_HOLD;
        end
      end
      ST_STOP_HOLD: begin
        if (stat.timerDone) begin
          stb.rstRelease = 1'b1;
          stb.timerLoad = 1'b1;
          stb.dlySel = DLY_SETTLE;
          nextState = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (stat.timerDone) nextState = ST_DONE;
      end
      ST_DONE: begin
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy        = (state != ST_IDLE);
  assign clearSticky = (state == ST_CLEAR);
  assign donePulse   = (state == ST_DONE);

endmodule

// File: rtl/i2cBusRecover.sv
module i2cBusRecover
  import i2cRecoverPkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int POLL_LIMIT = 10,
  parameter int POLL_WAIT_US = 500,
  parameter int PULSE_LIMIT = 10,
  parameter int HALF_US = 100,
  parameter int HOLD_US = 1000,
  parameter int SETTLE_US = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic startPulse,
  input  logic pendingIn,
  input  logic sclIn,
  input  logic sdaIn,
  output logic busy,
  output logic donePulse,
  output logic clearSticky,
  output logic ctrlSoftReset,
  output logic sclDriveLow,
  output logic sdaDriveLow
);

  recStrobe_t stb;
  recStatus_t stat;

  i2cRecoverControl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .startPulse(startPulse),
    .pendingIn(pendingIn),
    .stat(stat),
    .stb(stb),
    .busy(busy),
    .clearSticky(clearSticky),
    .donePulse(donePulse)
  );

  i2cRecoverDatapath #(
    .CLK_PER_US(CLK_PER_US),
    .POLL_LIMIT(POLL_LIMIT),
    .POLL_WAIT_US(POLL_WAIT_US),
    .PULSE_LIMIT(PULSE_LIMIT),
    .HALF_US(HALF_US),
    .HOLD_US(HOLD_US),
    .SETTLE_US(SETTLE_US),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .stat(stat),
    .ctrlSoftReset(ctrlSoftReset),
    .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2cBusRecoverChk.sv
module i2cBusRecoverChk #(
  parameter int PULSE_LIMIT = 10
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic donePulse,
  input logic clearSticky,
  input logic ctrlSoftReset,
  input logic sclDriveLow,
  input logic sdaDriveLow
);

  localparam int SEEN_W = $clog2(PULSE_LIMIT + 2) + 1;

  logic [SEEN_W-1:0] pulseSeen;
  logic              sclPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseSeen <= '0;
      sclPrev   <= 1'b0;
    end else begin
      sclPrev <= sclDriveLow;
      if (!ctrlSoftReset)             pulseSeen <= '0;
      else if (sclDriveLow && !sclPrev) pulseSeen <= pulseSeen + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ctrlSoftReset && !sclDriveLow && !sdaDriveLow && !clearSticky)); // R1

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    clearSticky |=> !clearSticky); // R1

  AST_RESET_COVERS_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (sclDriveLow || sdaDriveLow) |-> ctrlSoftReset); // R3

  AST_SDA_IDLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> !sdaDriveLow); // R4

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseSeen <= SEEN_W'(PULSE_LIMIT)); // R5

  AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclDriveLow); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy)); // R7

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!ctrlSoftReset && !sclDriveLow && !sdaDriveLow)); // R7

endmodule

bind i2cBusRecover i2cBusRecoverChk #(
  .PULSE_LIMIT(PULSE_LIMIT)
) chk_i (
  .clk(clk),
  .rstN(rstN),
  .busy(busy),
  .donePulse(donePulse),
  .clearSticky(clearSticky),
  .ctrlSoftReset(ctrlSoftReset),
  .sclDriveLow(sclDriveLow),
  .sdaDriveLow(sdaDriveLow)
);

// File: tb/i2cBusRecover_tb_top.sv
module i2cBusRecover_tb_top;

  localparam int CPU = 2;
  localparam int PLIM = 10;
  localparam int PWAIT = 5;
  localparam int PULIM = 10;
  localparam int HALF = 3;
  localparam int HOLD = 10;
  localparam int SETTLE = 10;

  localparam int EV_CLEAR = 0;
  localparam int EV_RST_ON = 1;
  localparam int EV_PULSE = 2;
  localparam int EV_GAP = 3;
  localparam int EV_START = 4;
  localparam int EV_STOP = 5;
  localparam int EV_RST_OFF = 6;
  localparam int EV_DONE = 7;

  typedef struct {
    int    kind;
    int    value;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic pendingIn = 1'b0;
  logic sclIn, sdaIn;
  logic busy, donePulse, clearSticky, ctrlSoftReset, sclDriveLow, sdaDriveLow;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  item_t expQ[$];

  int stuckLeft = 0;
  logic sclStuck = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sdaIn = !(sdaDriveLow || (stuckLeft > 0));
  assign sclIn = !(sclDriveLow || sclStuck);

  i2cBusRecover #(
    .CLK_PER_US(CPU),
    .POLL_LIMIT(PLIM),
    .POLL_WAIT_US(PWAIT),
    .PULSE_LIMIT(PULIM),
    .HALF_US(HALF),
    .HOLD_US(HOLD),
    .SETTLE_US(SETTLE),
    .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk),
    .rstN(rstN),
    .startPulse(startPulse),
    .pendingIn(pendingIn),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .busy(busy),
    .donePulse(donePulse),
    .clearSticky(clearSticky),
    .ctrlSoftReset(ctrlSoftReset),
    .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pushExp(input int kind, input int value, input string tag);
    item_t it;
    it.kind = kind;
    it.value = value;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic compareObs(input int kind, input int value);
    item_t it;
    compared++;
    if (expQ.size() == 0) begin
      mismatched++;
      $display("FAIL R8 unexpected event kind %0d: actual value %0d expected no event", kind, value);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || it.value != value) begin
        mismatched++;
        $display("FAIL %s event: actual kind %0d value %0d expected kind %0d value %0d",
                 it.tag, kind, value, it.kind, it.value);
      end
    end
  endtask

  // bus device model: holds SDA low until it has seen stuckLeft SCL releases
  logic sclDrvPrev = 1'b0;
  always @(negedge clk) begin
    if (sclDrvPrev && !sclDriveLow && stuckLeft > 0) stuckLeft <= stuckLeft - 1;
    sclDrvPrev <= sclDriveLow;
  end

  // monitor
  logic pScl = 1'b0, pSda = 1'b0, pRst = 1'b0;
  int clearCyc = 0, sclRiseCyc = 0, sclFallCyc = 0, sdaRiseCyc = 0, sdaFallCyc = 0, rstFallCyc = 0;
  int pulsesInRun = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (clearSticky) begin
        clearCyc = cyc;
        pulsesInRun = 0;
        compareObs(EV_CLEAR, 0);
      end
      if (ctrlSoftReset && !pRst) compareObs(EV_RST_ON, cyc - clearCyc);
      if (sclDriveLow && !pScl) begin
        if (pulsesInRun > 0) compareObs(EV_GAP, cyc - sclFallCyc);
        sclRiseCyc = cyc;
        pulsesInRun++;
      end
      if (!sclDriveLow && pScl) begin
        sclFallCyc = cyc;
        compareObs(EV_PULSE, cyc - sclRiseCyc);
      end
      if (sdaDriveLow && !pSda) begin
        sdaRiseCyc = cyc;
        compareObs(EV_START, {30'd0, ctrlSoftReset, !sclDriveLow});
      end
      if (!sdaDriveLow && pSda) begin
        sdaFallCyc = cyc;
        compareObs(EV_STOP, cyc - sdaRiseCyc);
      end
      if (!ctrlSoftReset && pRst) begin
        rstFallCyc = cyc;
        compareObs(EV_RST_OFF, cyc - sdaFallCyc);
      end
      if (donePulse) compareObs(EV_DONE, cyc - rstFallCyc);
    end
    pScl = sclDriveLow;
    pSda = sdaDriveLow;
    pRst = ctrlSoftReset;
  end

  // driver: sets the scenario, predicts the event stream, starts the run
  task automatic runRecovery(input logic pendAll, input int stuck, input logic stkScl,
                             input logic extraStart);
    int nPulses;
    int rstOn;
    int waitCnt;
    nPulses = stkScl ? PULIM : ((stuck < PULIM) ? stuck : PULIM);
    rstOn = pendAll ? 2 + (PLIM - 1) * (PWAIT * CPU + 2) : 2;
    pushExp(EV_CLEAR, 0, "R1");
    pushExp(EV_RST_ON, rstOn, "R2");
    for (int i = 0; i < nPulses; i++) begin
      if (i > 0) pushExp(EV_GAP, HALF * CPU + 2, "R4");
      pushExp(EV_PULSE, HALF * CPU + 1, (i == PULIM - 1) ? "R5" : "R4");
    end
    pushExp(EV_START, 3, "R6");
    pushExp(EV_STOP, HOLD * CPU + 1, "R6");
    pushExp(EV_RST_OFF, HOLD * CPU + 1, "R3");
    pushExp(EV_DONE, SETTLE * CPU + 1, "R7");

    @(negedge clk);
    pendingIn = pendAll;
    stuckLeft = stuck;
    sclStuck = stkScl;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    if (extraStart) begin
      repeat (20) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    waitCnt = 0;
    while (!donePulse && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(donePulse == 1'b1, "R7 done seen", donePulse, 1);
    @(negedge clk);
    check(busy == 1'b0, "R7 busy low after done", busy, 0);
    pendingIn = 1'b0;
    sclStuck = 1'b0;
    stuckLeft = 0;
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R8 idle after run", busy, 0);
    check(expQ.size() == 0, "R8 all predicted events seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(ctrlSoftReset == 1'b0, "R1 reset softReset", ctrlSoftReset, 0);
    check(sclDriveLow == 1'b0 && sdaDriveLow == 1'b0, "R1 reset drives",
          {sclDriveLow, sdaDriveLow}, 0);
    check(donePulse == 1'b0 && clearSticky == 1'b0, "R1 reset strobes",
          {donePulse, clearSticky}, 0);

    runRecovery(1'b0, 0, 1'b0, 1'b0);   // R6 clean bus: no pulses
    runRecovery(1'b0, 3, 1'b0, 1'b0);   // R4 device lets go after 3 clocks
    runRecovery(1'b1, 1, 1'b0, 1'b0);   // R2 pending never clears
    runRecovery(1'b0, 15, 1'b0, 1'b0);  // R5 device holds past the limit
    runRecovery(1'b0, 0, 1'b1, 1'b0);   // R5 SCL stuck low
    runRecovery(1'b0, 4, 1'b0, 1'b1);   // R8 second start while busy

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule